// File: doc/BRIEF.md
# Null-Frame Payload Stuffing Inserter

This block sits on a byte-wide transport stream that an upstream synchronizer has already aligned to 16-byte frames and marked with a lock flag. It passes every byte through after a fixed three-stage delay. When a frame turns out to be an empty (null) frame, the block fills that frame's payload slots with user bytes taken from a side input.

User bytes may be written on the side input at any time. They wait in a small first-in first-out buffer until a null frame comes along. A frame counts as null when it opens with 0x47 and its next two bytes are 0x1F and then 0xFF. The three header bytes always go out untouched. Only the payload slots, bytes 3 to 15, can be replaced, and only while the lock flag was high when the byte entered.

The delay line is three bytes deep. This lets the whole header be inspected before the first payload byte reaches the output. The side source is throttled only by a full flag.

Top module: `nullfill_inserter`

## Requirements
- R1: A synchronous reset drives `tsOut` to 0x00 and `usrFull` to 0.
- R2: A byte sampled on `tsIn` at a clock edge is visible on `tsOut` after the third edge that follows, and stays there for one cycle, unless it is replaced.
- R3: In a null frame, each payload byte at index 3 to 15 is replaced by the oldest buffered user byte while the buffer is non-empty. A null frame is one whose bytes at index 0, 1 and 2 are 0x47, 0x1F and 0xFF.
- R4: The three header bytes of a null frame are forwarded unchanged.
- R5: Buffered user bytes leave in the order they were written, also across consecutive null frames.
- R6: If the buffer is empty when a null-frame payload slot is output, the original stream byte is forwarded in that slot.
- R7: A frame whose first three bytes differ from the null signature in any position passes unchanged and consumes no buffered bytes.
- R8: Bytes sampled while `lockIn` is low are never replaced. The frame index is held at 0 while unlocked, so the first locked byte is index 0.
- R9: `usrFull` rises in the cycle after the buffer holds 16 bytes. A write made while full is discarded and never appears on the output.
- R10: A synchronous reset empties the buffer, clears the byte counter and zeroes the delay line, so bytes buffered before the reset are never inserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one stream byte per cycle |
| rst | input | 1 | Synchronous reset, active high |
| lockIn | input | 1 | Frame lock from the upstream synchronizer |
| tsIn | input | 8 | Frame-aligned stream byte |
| usrWrEn | input | 1 | Write strobe for the side data |
| usrData | input | 8 | Side data byte |
| tsOut | output | 8 | Output stream byte, three cycles behind `tsIn` |
| usrFull | output | 1 | Side buffer holds 16 bytes |

## Verification
Every output byte is due exactly three clock edges after its input byte was sampled. The bench drives and samples on falling edges and keeps a three-entry queue of expected bytes, so each comparison meets the byte driven three falling edges earlier. Expected stuffing values come from a bench-side queue model that is filled before each frame starts, so no buffer write can race a payload slot. `usrFull` is due one edge after the sixteenth write and is checked at the next falling edge. After a reset the first three output slots are expected as zero, because the delay line was cleared.

// File: rtl/nullfill_pkg.sv
package nullfill_pkg;

  localparam int BYTE_W     = 8;
  // Header length and delay-line depth are the same number by design.
  localparam int PIPE_DEPTH = 3;

  typedef logic [BYTE_W-1:0] byte_t;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic stuff;  // select buffered byte onto the output
    logic pop;    // advance the side buffer
  } strobe_t;

  // Null-frame signature, byte k of the frame header.
  function automatic byte_t hdrByte(input int k);
    case (k)
      0:       hdrByte = 8'h47;
      1:       hdrByte = 8'h1F;
      default: hdrByte = 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/nullfill_fifo.sv
module nullfill_fifo
  import nullfill_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  byte_t            wrData,
  input  logic             rdEn,
  output byte_t            rdData,
  output logic             empty,
  output logic             full,
  output logic [LVL_W-1:0] level
);

  byte_t            mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             doWr, doRd;

  assign full   = (level == LVL_W'(DEPTH));
  assign empty  = (level == '0);
  assign doWr   = wrEn && !full;
  assign doRd   = rdEn && !empty;
  assign rdData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    nextPtr = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doWr) wrPtr <= nextPtr(wrPtr);
      if (doRd) rdPtr <= nextPtr(rdPtr);
      case ({doWr, doRd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/nullfill_ctrl.sv
module nullfill_ctrl
  import nullfill_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  localparam int IDX_W = $clog2(FRAME_LEN)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             lockIn,
  input  logic [PIPE_DEPTH-1:0][BYTE_W-1:0] stgByte,
  input  logic [PIPE_DEPTH-1:0][IDX_W-1:0]  stgIdx,
  input  logic [PIPE_DEPTH-1:0]            stgLock,
  input  logic                             fifoEmpty,
  output logic [IDX_W-1:0]                 frameIdx,
  output strobe_t                          strb
);

  localparam int LAST = PIPE_DEPTH - 1;

  logic [PIPE_DEPTH-1:0] hdrHit;
  logic                  frameNull;
  logic                  inPayload;

  // Byte counter: held at 0 while unlocked, wraps at the frame length.
  always_ff @(posedge clk) begin
    if (rst || !lockIn)                          frameIdx <= '0;
    else if (frameIdx == IDX_W'(FRAME_LEN - 1))  frameIdx <= '0;
    else                                         frameIdx <= frameIdx + 1'b1;
  end

  // The oldest stage holds header byte 0, the newest the last header byte.
  genvar k;
  generate
    for (k = 0; k < PIPE_DEPTH; k++) begin : g_hdr
      assign hdrHit[k] = stgLock[k]
                      && (stgIdx[k]  == IDX_W'(LAST - k))
                      && (stgByte[k] == hdrByte(LAST - k));
    end
  endgenerate

  // Latch the verdict as header byte 0 leaves; it governs the rest of the frame.
  always_ff @(posedge clk) begin
    if (rst || !stgLock[LAST])     frameNull <= 1'b0;
    else if (stgIdx[LAST] == '0)   frameNull <= &hdrHit;
  end

  assign inPayload = stgLock[LAST] && (stgIdx[LAST] >= IDX_W'(PIPE_DEPTH));

  always_comb begin
    strb       = '0;
    strb.stuff = frameNull && inPayload && !fifoEmpty;
    strb.pop   = strb.stuff;
  end

endmodule

// File: rtl/nullfill_datapath.sv
module nullfill_datapath
  import nullfill_pkg::*;
#(
  parameter int FRAME_LEN  = 16,
  parameter int FIFO_DEPTH = 16,
  localparam int IDX_W = $clog2(FRAME_LEN),
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              lockIn,
  input  byte_t                             tsIn,
  input  logic [IDX_W-1:0]                  frameIdx,
  input  logic                              usrWrEn,
  input  byte_t                             usrData,
  input  strobe_t                           strb,
  output logic [PIPE_DEPTH-1:0][BYTE_W-1:0] stgByte,
  output logic [PIPE_DEPTH-1:0][IDX_W-1:0]  stgIdx,
  output logic [PIPE_DEPTH-1:0]             stgLock,
  output logic                              fifoEmpty,
  output logic                              fifoFull,
  output logic [LVL_W-1:0]                  fifoLevel,
  output byte_t                             tsOut
);

  byte_t headByte;

  // Delay line: each stage carries the byte, its frame index and its lock bit.
  genvar s;
  generate
    for (s = 0; s < PIPE_DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) begin
            stgByte[s] <= '0;
            stgIdx[s]  <= '0;
            stgLock[s] <= 1'b0;
          end else begin
            stgByte[s] <= tsIn;
            stgIdx[s]  <= frameIdx;
            stgLock[s] <= lockIn;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) begin
            stgByte[s] <= '0;
            stgIdx[s]  <= '0;
            stgLock[s] <= 1'b0;
          end else begin
            stgByte[s] <= stgByte[s-1];
            stgIdx[s]  <= stgIdx[s-1];
            stgLock[s] <= stgLock[s-1];
          end
        end
      end
    end
  endgenerate

  nullfill_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk    (clk),
    .rst    (rst),
    .wrEn   (usrWrEn),
    .wrData (usrData),
    .rdEn   (strb.pop),
    .rdData (headByte),
    .empty  (fifoEmpty),
    .full   (fifoFull),
    .level  (fifoLevel)
  );

  assign tsOut = strb.stuff ? headByte : stgByte[PIPE_DEPTH-1];

endmodule

// File: rtl/nullfill_inserter.sv
module nullfill_inserter
  import nullfill_pkg::*;
#(
  parameter int FRAME_LEN  = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lockIn,
  input  logic [7:0] tsIn,
  input  logic       usrWrEn,
  input  logic [7:0] usrData,
  output logic [7:0] tsOut,
  output logic       usrFull
);

  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  logic [PIPE_DEPTH-1:0][BYTE_W-1:0] stgByte;
  logic [PIPE_DEPTH-1:0][IDX_W-1:0]  stgIdx;
  logic [PIPE_DEPTH-1:0]             stgLock;
  logic [IDX_W-1:0]                  frameIdx;
  logic                              fifoEmpty;
  logic [LVL_W-1:0]                  fifoLevel;
  strobe_t                           strb;

  nullfill_ctrl #(.FRAME_LEN(FRAME_LEN)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .lockIn    (lockIn),
    .stgByte   (stgByte),
    .stgIdx    (stgIdx),
    .stgLock   (stgLock),
    .fifoEmpty (fifoEmpty),
    .frameIdx  (frameIdx),
    .strb      (strb)
  );

  nullfill_datapath #(.FRAME_LEN(FRAME_LEN), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .lockIn    (lockIn),
    .tsIn      (tsIn),
    .frameIdx  (frameIdx),
    .usrWrEn   (usrWrEn),
    .usrData   (usrData),
    .strb      (strb),
    .stgByte   (stgByte),
    .stgIdx    (stgIdx),
    .stgLock   (stgLock),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (usrFull),
    .fifoLevel (fifoLevel),
    .tsOut     (tsOut)
  );

endmodule

// File: rtl/nullfill_chk.sv
module nullfill_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             lockIn,
  input logic [7:0]       tsIn,
  input logic [7:0]       tsOut,
  input logic             usrWrEn,
  input logic             usrFull,
  input logic             stuffing,
  input logic             fifoEmpty,
  input logic [LVL_W-1:0] fifoLevel
);

  // Cycles since reset, saturating at the delay-line depth.
  logic [1:0] sinceRst;
  logic       warm;
  always_ff @(posedge clk) begin
    if (rst)                 sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 1'b1;
  end
  assign warm = (sinceRst == 2'd3);

  a_r2_passthrough: assert property (@(posedge clk) disable iff (rst)
    (warm && !stuffing) |-> (tsOut == $past(tsIn, 3)));

  a_r8_locked_only: assert property (@(posedge clk) disable iff (rst)
    (warm && stuffing) |-> $past(lockIn, 3));

  a_r6_no_empty_pop: assert property (@(posedge clk) disable iff (rst)
    stuffing |-> !fifoEmpty);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    fifoLevel <= LVL_W'(DEPTH));

  a_r9_drop_when_full: assert property (@(posedge clk) disable iff (rst)
    (usrFull && usrWrEn && !stuffing) |=> (fifoLevel == $past(fifoLevel)));

  a_r5_accept_write: assert property (@(posedge clk) disable iff (rst)
    (usrWrEn && !usrFull && !stuffing) |=> (fifoLevel == $past(fifoLevel) + 1'b1));

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (fifoLevel == '0 && !usrFull));

endmodule

bind nullfill_inserter nullfill_chk #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lockIn    (lockIn),
  .tsIn      (tsIn),
  .tsOut     (tsOut),
  .usrWrEn   (usrWrEn),
  .usrFull   (usrFull),
  .stuffing  (strb.stuff),
  .fifoEmpty (fifoEmpty),
  .fifoLevel (fifoLevel)
);

// File: tb/sim_nullfill_inserter.sv
`timescale 1ns/1ps
module sim_nullfill_inserter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lockIn = 1'b0;
  logic [7:0] tsIn = '0;
  logic       usrWrEn = 1'b0;
  logic [7:0] usrData = '0;
  logic [7:0] tsOut;
  logic       usrFull;

  always #2.5 clk = ~clk;

  nullfill_inserter u0 (
    .clk(clk), .rst(rst), .lockIn(lockIn), .tsIn(tsIn),
    .usrWrEn(usrWrEn), .usrData(usrData), .tsOut(tsOut), .usrFull(usrFull)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Expected-output queue: entry 2 is due at the current falling edge.
  logic [7:0] qB [3];
  string      qT [3];
  bit         qV [3];
  logic [7:0] model [$];
  logic [7:0] nextData = 8'hC0;

  typedef struct packed {
    logic       lk;
    logic [7:0] h0;
    logic [7:0] h1;
    logic [7:0] h2;
    logic [7:0] pre;
  } scen_t;

  // lock, header bytes, user bytes buffered before the frame
  localparam scen_t SCN [9] = '{
    '{1'b1, 8'h47, 8'h1F, 8'hFF, 8'd13},   // R3 whole payload stuffed
    '{1'b1, 8'h47, 8'h1F, 8'hFF, 8'd5},    // R6 buffer runs dry
    '{1'b1, 8'h47, 8'h1F, 8'hFE, 8'd4},    // R7 last header byte off
    '{1'b1, 8'h47, 8'h1F, 8'hFF, 8'd0},    // R3 uses leftovers
    '{1'b1, 8'h46, 8'h1F, 8'hFF, 8'd3},    // R7 bad sync byte
    '{1'b0, 8'h47, 8'h1F, 8'hFF, 8'd2},    // R8 unlocked
    '{1'b1, 8'h47, 8'h1F, 8'hFF, 8'd10},   // R3 deep buffer
    '{1'b1, 8'h47, 8'h0F, 8'hFF, 8'd0},    // R7 middle header byte off
    '{1'b1, 8'h47, 8'h1F, 8'hFF, 8'd0}     // R6 partial leftovers
  };

  task automatic check(input string tg, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tg, act, exp, $time);
    end
  endtask

  task automatic drive(input bit lk, input logic [7:0] b, input bit wr,
                       input logic [7:0] wd, input logic [7:0] ex,
                       input string tg, input int expFull);
    @(negedge clk);
    if (qV[2]) check(qT[2], tsOut, qB[2]);
    if (expFull >= 0) check("R9", {7'd0, usrFull}, 8'(expFull));
    qB[2] = qB[1]; qT[2] = qT[1]; qV[2] = qV[1];
    qB[1] = qB[0]; qT[1] = qT[0]; qV[1] = qV[0];
    qB[0] = ex;    qT[0] = tg;    qV[0] = 1'b1;
    lockIn = lk; tsIn = b; usrWrEn = wr; usrData = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 8'h00, 1'b0, 8'h00, 8'h00, "R2", -1);
  endtask

  task automatic preload(input int n);
    for (int i = 0; i < n; i++) begin
      drive(1'b0, 8'h00, 1'b1, nextData, 8'h00, "R2", -1);
      if (model.size() < 16) model.push_back(nextData);
      nextData++;
    end
  endtask

  task automatic sendFrame(input bit lk, input logic [7:0] h0, input logic [7:0] h1,
                           input logic [7:0] h2, input int s,
                           input string stuffTag, input string dryTag);
    bit isNull;
    isNull = (h0 == 8'h47) && (h1 == 8'h1F) && (h2 == 8'hFF);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b, ex;
      string tg;
      b = (i == 0) ? h0 : (i == 1) ? h1 : (i == 2) ? h2 : 8'((s % 16) * 16 + i);
      if (!lk)                   begin ex = b; tg = "R8"; end
      else if (!isNull)          begin ex = b; tg = "R7"; end
      else if (i < 3)            begin ex = b; tg = "R4"; end
      else if (model.size() > 0) begin ex = model.pop_front(); tg = stuffTag; end
      else                       begin ex = b; tg = dryTag; end
      drive(lk, b, 1'b0, 8'h00, ex, tg, -1);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; lockIn = 1'b1; tsIn = 8'h5A; usrWrEn = 1'b1; usrData = 8'h33;
    repeat (2) @(negedge clk);
    rst = 1'b0; lockIn = 1'b0; tsIn = 8'h00; usrWrEn = 1'b0;
    for (int i = 0; i < 3; i++) begin qB[i] = 8'h00; qT[i] = "R10"; qV[i] = 1'b1; end
    model.delete();
  endtask

  initial begin
    for (int i = 0; i < 3; i++) qV[i] = 1'b0;
    doReset();
    check("R1", tsOut, 8'h00);
    check("R1", {7'd0, usrFull}, 8'h00);

    // Table of scenarios, one frame each.
    for (int s = 0; s < 9; s++) begin
      preload(int'(SCN[s].pre));
      idle(3);
      sendFrame(SCN[s].lk, SCN[s].h0, SCN[s].h1, SCN[s].h2, s, "R3", "R6");
      idle(3);
    end

    // Full buffer, dropped write, order over two back-to-back null frames.
    doReset();
    for (int i = 0; i < 15; i++) preload(1);
    drive(1'b0, 8'h00, 1'b1, nextData, 8'h00, "R2", 0);      // 16th write
    model.push_back(nextData); nextData++;
    drive(1'b0, 8'h00, 1'b1, 8'hEE, 8'h00, "R2", 1);         // dropped
    drive(1'b0, 8'h00, 1'b0, 8'h00, 8'h00, "R2", 1);
    idle(2);
    sendFrame(1'b1, 8'h47, 8'h1F, 8'hFF, 10, "R5", "R6");
    sendFrame(1'b1, 8'h47, 8'h1F, 8'hFF, 11, "R5", "R6");
    idle(3);

    // Reset discards buffered bytes.
    preload(5);
    idle(1);
    doReset();
    idle(3);
    sendFrame(1'b1, 8'h47, 8'h1F, 8'hFF, 12, "R3", "R10");
    idle(4);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule